// File: doc/BRIEF.md
# Cycle-by-Cycle Current-Limited PWM Pair

This block drives a pair of PWM outputs, A and B, from one period counter. Period and duty are programmable. A free-running counter steps from zero to period minus one. At each period start the block takes a fresh copy of the period, the duty and the output mode. In complementary mode A covers the duty portion and B covers the rest. In identical-duty mode both outputs carry the same pulse width: A's pulse starts at count zero and B's pulse starts at half the period. A strobe marks the first count of every period.

A synchronous current-limit input ends the output pulse that is active when the input is seen high. In complementary mode this ends A early, and B takes over for the rest of the period. In identical-duty mode it cuts whichever of A or B is high. With escalation disabled, each limit event acts only on the current period. With escalation enabled, limit events are counted. Once the count passes a programmed maximum, a fault latches and holds both outputs low until the enable is dropped and raised again.

Top module: `cbc_pwm`

## Requirements
- R1: While `en` is low, `pwm_a`, `pwm_b`, `fault` and `period_start` are all 0, and the limit-event count is cleared. The same holds after reset.
- R2: The first period begins on the clock edge after `en` is seen high. The counter runs 0 to P-1, where P is `period` taken at period start, and any value below 2 is taken as 2. `period_start` is high exactly while the count is 0. `period`, `duty` and `mode` are taken only at period start.
- R3: In complementary mode (`mode`=0), with D the captured duty, `pwm_a` is 1 while count < D and `pwm_b` is 1 for the rest of the period. D=0 gives A off for the whole period, and D>=P gives A on for the whole period.
- R4: In complementary mode, if `ilim` is sampled 1 on an edge while `pwm_a` is 1, then from the next cycle `pwm_a` is 0 and `pwm_b` is 1 until the period ends.
- R5: In identical-duty mode (`mode`=1), let H = P/2 (rounded down) and E = min(D,H). `pwm_a` is 1 for count < E, and `pwm_b` is 1 for H <= count < H+E. The two outputs are never 1 together.
- R6: In identical-duty mode, an `ilim` sample at 1 clears only the output that is 1 in that cycle, for the rest of the period. A sample taken while both outputs are 0 has no effect.
- R7: With `fault_en`=0, a limit event lasts only for its own period. Normal pulses resume at the next period start, and `fault` stays 0.
- R8: With `fault_en`=1, every limit event adds one to a saturating count. `fault` rises on the cycle after the event that makes the count exceed `max_evt`. With `max_evt`=0 the first event latches it.
- R9: While `fault` is 1, `pwm_a` and `pwm_b` are 0 in every period. `fault` stays 1 until `en` is sampled 0, and it is 0 again after `en` returns high.
- R10: In complementary mode, an `ilim` sample taken after A has ended in the current period is ignored, and `pwm_b` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears the count and the fault |
| period | input | CNT_W | Period length in clocks |
| duty | input | CNT_W | Pulse width in clocks |
| mode | input | 1 | 0 = complementary, 1 = identical-duty |
| ilim | input | 1 | Current-limit comparator result, synchronous |
| fault_en | input | 1 | Enables counting of limit events and fault escalation |
| max_evt | input | EVT_W | Largest event count that does not yet latch the fault |
| pwm_a | output | 1 | Output A |
| pwm_b | output | 1 | Output B |
| fault | output | 1 | Latched fault |
| period_start | output | 1 | High on count 0 of each period |

## Verification
Two things can land on the same clock edge: a limit event on the last count of a period, and the period wrap that re-arms the limit. When that happens the event must still be counted toward escalation, but it must not truncate the new period. The bench provokes this with a limit input that pulses on a fixed stride unrelated to the period, together with full-duty settings. A behavioural model in the bench judges every cycle. The same model covers the other coincidence, where the escalating event truncates the output and latches the fault in one edge.

// File: rtl/cbc_pwm_pkg.sv
package cbc_pwm_pkg;
    typedef enum logic {
        MODE_COMP  = 1'b0,
        MODE_IDENT = 1'b1
    } pwm_mode_e;
endpackage

// File: rtl/cbc_pwm_timebase.sv
module cbc_pwm_timebase
    import cbc_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  pwm_mode_e        mode,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] per_l,
    output logic [CNT_W-1:0] duty_l,
    output pwm_mode_e        mode_l,
    output logic             run,
    output logic             new_period
);
    localparam logic [CNT_W-1:0] MIN_PER = CNT_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        pwm_mode_e        mode;
        logic             run;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      wrap;

    always_comb begin
        st_d       = st_q;
        wrap       = (st_q.cnt == st_q.per - CNT_W'(1));
        new_period = en && (!st_q.run || wrap);
        if (!en) begin
            st_d.cnt = '0;
            st_d.run = 1'b0;
        end else if (new_period) begin
            st_d.cnt  = '0;
            st_d.per  = (period < MIN_PER) ? MIN_PER : period;
            st_d.duty = duty;
            st_d.mode = mode;
            st_d.run  = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, per: MIN_PER, duty: '0, mode: MODE_COMP, run: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt    = st_q.cnt;
    assign per_l  = st_q.per;
    assign duty_l = st_q.duty;
    assign mode_l = st_q.mode;
    assign run    = st_q.run;

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt < st_q.per)) else $error("count beyond period"); // R2
    AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !st_q.run) else $error("still running while disabled"); // R1
endmodule

// File: rtl/cbc_pwm_window.sv
module cbc_pwm_window
    import cbc_pwm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] per_l,
    input  logic [CNT_W-1:0] duty_l,
    input  pwm_mode_e        mode_l,
    output logic             win_a,
    output logic             win_b
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] eff;
    logic [EXT_W-1:0] b_end;

    always_comb begin
        half  = per_l >> 1;
        eff   = (duty_l < half) ? duty_l : half;
        b_end = {1'b0, half} + {1'b0, eff};
        if (mode_l == MODE_IDENT) begin
            win_a = (cnt < eff);
            win_b = (cnt >= half) && ({1'b0, cnt} < b_end);
        end else begin
            win_a = (cnt < duty_l);
            win_b = !(cnt < duty_l);
        end
    end
endmodule

// File: rtl/cbc_pwm_guard.sv
module cbc_pwm_guard
    import cbc_pwm_pkg::*;
#(
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             run,
    input  logic             new_period,
    input  pwm_mode_e        mode_l,
    input  logic             win_a,
    input  logic             win_b,
    input  logic             ilim,
    input  logic             fault_en,
    input  logic [EVT_W-1:0] max_evt,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             fault
);
    localparam logic [EVT_W-1:0] EVT_SAT = {EVT_W{1'b1}};

    typedef struct packed {
        logic             lim_a;
        logic             lim_b;
        logic [EVT_W-1:0] evt;
        logic             fault;
    } gd_state_t;

    gd_state_t     gd_d, gd_q;
    logic          live;
    logic          ev_a, ev_b;
    logic [EVT_W:0] evt_next;

    always_comb begin
        live  = run && !gd_q.fault;
        pwm_a = live && win_a && !gd_q.lim_a;
        if (mode_l == MODE_IDENT) begin
            pwm_b = live && win_b && !gd_q.lim_b;
        end else begin
            pwm_b = live && !(win_a && !gd_q.lim_a);
        end
        ev_a     = ilim && pwm_a;
        ev_b     = ilim && pwm_b && (mode_l == MODE_IDENT);
        evt_next = {1'b0, gd_q.evt} + {{EVT_W{1'b0}}, 1'b1};

        gd_d = gd_q;
        if (!en) begin
            gd_d = '0;
        end else begin
            if (fault_en && (ev_a || ev_b)) begin
                if (evt_next > {1'b0, max_evt}) gd_d.fault = 1'b1;
                if (gd_q.evt != EVT_SAT) gd_d.evt = evt_next[EVT_W-1:0];
            end
            if (new_period) begin
                gd_d.lim_a = 1'b0;
                gd_d.lim_b = 1'b0;
            end else begin
                gd_d.lim_a = gd_q.lim_a || ev_a;
                gd_d.lim_b = gd_q.lim_b || ev_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gd_q <= '0;
        else        gd_q <= gd_d;
    end

    assign fault = gd_q.fault;

    AST_FAULT_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
        gd_q.fault |-> (!pwm_a && !pwm_b)) else $error("output active in fault"); // R9
    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (gd_q.fault && en) |=> gd_q.fault) else $error("fault released while enabled"); // R9
    AST_IDENT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_l == MODE_IDENT) |-> !(pwm_a && pwm_b)) else $error("both outputs high"); // R5
    AST_COMP_B_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (gd_q.lim_a && run && !gd_q.fault && mode_l == MODE_COMP) |-> pwm_b)
        else $error("B not filling after limit"); // R4
    AST_IDLE_LIMIT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ilim && !pwm_a && !pwm_b && !new_period)
            |=> ($stable(gd_q.lim_a) && $stable(gd_q.lim_b)))
        else $error("limit acted while no pulse"); // R6
endmodule

// File: rtl/cbc_pwm.sv
module cbc_pwm
    import cbc_pwm_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int EVT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] duty,
    input  logic             mode,
    input  logic             ilim,
    input  logic             fault_en,
    input  logic [EVT_W-1:0] max_evt,
    output logic             pwm_a,
    output logic             pwm_b,
    output logic             fault,
    output logic             period_start
);
    logic [CNT_W-1:0] cnt, per_l, duty_l;
    pwm_mode_e        mode_l;
    logic             run, new_period, win_a, win_b;

    cbc_pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(en), .period(period), .duty(duty),
        .mode(pwm_mode_e'(mode)), .cnt(cnt), .per_l(per_l), .duty_l(duty_l),
        .mode_l(mode_l), .run(run), .new_period(new_period)
    );

    cbc_pwm_window #(.CNT_W(CNT_W)) u_win (
        .cnt(cnt), .per_l(per_l), .duty_l(duty_l), .mode_l(mode_l),
        .win_a(win_a), .win_b(win_b)
    );

    cbc_pwm_guard #(.EVT_W(EVT_W)) u_gd (
        .clk(clk), .rst_n(rst_n), .en(en), .run(run), .new_period(new_period),
        .mode_l(mode_l), .win_a(win_a), .win_b(win_b), .ilim(ilim),
        .fault_en(fault_en), .max_evt(max_evt), .pwm_a(pwm_a), .pwm_b(pwm_b),
        .fault(fault)
    );

    assign period_start = run && (cnt == '0);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && en) |=> !period_start) else $error("strobe longer than one cycle"); // R2
endmodule

// File: tb/cbc_pwm_test.sv
`timescale 1ns/1ps
module cbc_pwm_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] period = 8'd10;
    logic [7:0] duty = 8'd4;
    logic       mode = 1'b0;
    logic       ilim = 1'b0;
    logic       fault_en = 1'b0;
    logic [3:0] max_evt = 4'd0;
    logic       pwm_a, pwm_b, fault, period_start;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    cbc_pwm uut (
        .clk(clk), .rst_n(rst_n), .en(en), .period(period), .duty(duty),
        .mode(mode), .ilim(ilim), .fault_en(fault_en), .max_evt(max_evt),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .fault(fault), .period_start(period_start)
    );

    // behavioural reference
    int m_cnt, m_per, m_duty, m_mode, m_run, m_la, m_lb, m_evt, m_fault;
    int ea, eb, eps;

    function automatic void model_out(output int oa, output int ob, output int ops);
        int h, d;
        oa = 0; ob = 0;
        ops = (m_run != 0 && m_cnt == 0) ? 1 : 0;
        if (m_run != 0 && m_fault == 0) begin
            if (m_mode == 0) begin
                oa = (m_cnt < m_duty && m_la == 0) ? 1 : 0;
                ob = 1 - oa;
            end else begin
                h = m_per / 2;
                d = (m_duty < h) ? m_duty : h;
                oa = (m_cnt < d && m_la == 0) ? 1 : 0;
                ob = (m_cnt >= h && m_cnt < h + d && m_lb == 0) ? 1 : 0;
            end
        end
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int oa, ob, ops, eva, evb;
        if (!rst_n) begin
            m_cnt = 0; m_per = 2; m_duty = 0; m_mode = 0; m_run = 0;
            m_la = 0; m_lb = 0; m_evt = 0; m_fault = 0;
        end else if (!en) begin
            m_cnt = 0; m_run = 0; m_la = 0; m_lb = 0; m_evt = 0; m_fault = 0;
        end else begin
            model_out(oa, ob, ops);
            eva = (ilim && oa != 0) ? 1 : 0;
            evb = (ilim && ob != 0 && m_mode == 1) ? 1 : 0;
            if (fault_en && (eva + evb) > 0) begin
                if (m_evt + 1 > int'(max_evt)) m_fault = 1;
                if (m_evt < 15) m_evt = m_evt + 1;
            end
            if (m_run == 0 || m_cnt == m_per - 1) begin
                m_cnt = 0; m_run = 1; m_la = 0; m_lb = 0;
                m_per = (period < 2) ? 2 : int'(period);
                m_duty = int'(duty); m_mode = int'(mode);
            end else begin
                m_cnt = m_cnt + 1;
                if (eva != 0) m_la = 1;
                if (evb != 0) m_lb = 1;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            model_out(ea, eb, eps);
            check(cur_req, "outputs {a,b,fault,start}",
                  {pwm_a, pwm_b, fault, period_start},
                  (ea << 3) | (eb << 2) | (m_fault << 1) | eps);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wait_start();
        @(negedge clk);
        while (!period_start) @(negedge clk);
    endtask

    // pulse ilim so it is sampled at count 1 of a period
    task automatic hit_early();
        wait_start();
        tick(1); ilim = 1'b1;
        tick(1); ilim = 1'b0;
        @(negedge clk);
    endtask

    task automatic restart();
        tick(1); en = 1'b0;
        tick(2); en = 1'b1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset and disabled state
        tick(3); rst_n = 1'b1;
        tick(3);
        @(negedge clk);
        check("R1", "idle outputs", {pwm_a, pwm_b, fault, period_start}, 0);

        // R2 R3 complementary basic
        cur_req = "R2"; tick(1); en = 1'b1;
        wait_start();
        check("R2", "start strobe", period_start, 1);
        cur_req = "R3"; tick(25);
        duty = 8'd0; tick(25);
        duty = 8'd12; tick(25);
        duty = 8'd3; period = 8'd1; cur_req = "R2"; tick(12);
        period = 8'd10; duty = 8'd4; tick(12);

        // R4 limit ends A, B fills
        cur_req = "R4";
        hit_early();
        check("R4", "A cut", pwm_a, 0);
        check("R4", "B fills", pwm_b, 1);
        // R7 re-arm next period
        cur_req = "R7";
        wait_start();
        check("R7", "A restored", pwm_a, 1);
        check("R7", "no fault", fault, 0);
        // R10 limit during B ignored
        cur_req = "R10";
        tick(5); ilim = 1'b1;
        tick(1); ilim = 1'b0;
        @(negedge clk);
        check("R10", "B kept", pwm_b, 1);
        // background stride of limit pulses, full duty for wrap coincidence
        duty = 8'd10;
        for (int i = 0; i < 60; i++) begin
            tick(1); ilim = ((i % 7) == 3);
        end
        ilim = 1'b0; duty = 8'd4;

        // R5 R6 identical-duty mode
        cur_req = "R5"; mode = 1'b1; duty = 8'd3; restart();
        tick(30);
        cur_req = "R6";
        hit_early();
        check("R6", "A cut", pwm_a, 0);
        check("R6", "B not on yet", pwm_b, 0);
        tick(3);
        @(negedge clk);
        check("R6", "B unaffected", pwm_b, 1);
        duty = 8'd9; period = 8'd11;
        for (int i = 0; i < 80; i++) begin
            tick(1); ilim = ((i % 5) == 2);
        end
        ilim = 1'b0; period = 8'd10; duty = 8'd4;

        // R8 R9 escalation, max 2
        cur_req = "R8"; mode = 1'b0; fault_en = 1'b1; max_evt = 4'd2; restart();
        hit_early();
        hit_early();
        check("R8", "no fault after 2", fault, 0);
        hit_early();
        check("R8", "fault after 3", fault, 1);
        cur_req = "R9";
        tick(25);
        @(negedge clk);
        check("R9", "fault held", fault, 1);
        check("R9", "outputs off", {pwm_a, pwm_b}, 0);
        tick(1); en = 1'b0;
        tick(1);
        @(negedge clk);
        check("R1", "fault cleared by disable", fault, 0);
        en = 1'b1;
        tick(12);
        @(negedge clk);
        check("R9", "running after re-enable", pwm_a | pwm_b, 1);

        // R8 max zero
        cur_req = "R8"; max_evt = 4'd0; restart();
        hit_early();
        check("R8", "first event latches", fault, 1);
        tick(15);
        fault_en = 1'b0; restart();
        cur_req = "R7";
        for (int i = 0; i < 40; i++) begin
            tick(1); ilim = ((i % 3) == 0);
        end
        ilim = 1'b0;
        @(negedge clk);
        check("R7", "no fault when disabled escalation", fault, 0);
        tick(5);
        finish_run();
    end
endmodule